// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small accumulator machine. It executes instructions as sequences of horizontal microinstructions held in an on-block control store. A control address register selects a word, and that word is captured in a control buffer register. The buffer drives one enable line per datapath transfer and bus operation. Its branch field and target field choose the next control address.

Each cycle the sequencer picks one of the following as its next address:
- the following word;
- a jump target;
- a target taken only when the mode bit or the interrupt request is set;
- the first word of the routine for the current opcode.

The fetch, indirect, interrupt, ADD, AND and idle routines each end by branching to another routine: fetch, indirect, interrupt or the opcode's own routine. When memory is not ready, a bus step is stretched: the sequencer holds its state and keeps that step's enables asserted.

Top module: `useq_ctrl`

## Requirements
- R1: While `rst_n` is low, and for the first two rising clock edges after it goes high, every control output is 0. After the third rising edge the first fetch step is presented.
- R2: Fetch is three steps, in this order: `mar_ld_pc`; then `bus_rd`+`mbr_ld_mem`+`pc_inc`; then `ir_ld_mbr`.
- R3: If `ir_ind` is 1 during the IR-load step, three indirect steps follow, in this order: `mar_ld_ir`; then `bus_rd`+`mbr_ld_mem`; then `ir_adr_ld`. The opcode's routine comes after them. If `ir_ind` is 0, the opcode's routine follows the IR-load step directly.
- R4: The ADD routine is three steps, in this order: `mar_ld_ir`; then `bus_rd`+`mbr_ld_mem`; then `acc_ld_add`.
- R5: The AND routine has the same first two steps as ADD. Its third step is `acc_ld_and`.
- R6: Opcode 0 selects AND and opcode 1 selects ADD. Every other opcode selects a single step with all outputs at 0. `opcode` is sampled in the cycle that the dispatching step is presented.
- R7: `irq` is sampled only in the last step of an opcode routine. If it is 1, the interrupt routine follows; if it is 0, fetch follows. At every other step `irq` has no effect on the outputs.
- R8: The interrupt routine is three steps, in this order: `mbr_ld_pc`; then `mar_ld_sav`+`pc_ld_isr`; then `bus_wr`. Fetch follows it.
- R9: While a step with `bus_rd` or `bus_wr` is presented and `mem_rdy` is 0, the same outputs repeat on the next cycle. `mem_rdy` has no effect during any other step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| opcode | input | OP_W | Instruction opcode from the IR path |
| ir_ind | input | 1 | Indirect-addressing mode bit |
| irq | input | 1 | Interrupt request |
| mem_rdy | input | 1 | Memory ready; 0 stretches a bus step |
| mar_ld_pc | output | 1 | MAR takes PC |
| mar_ld_ir | output | 1 | MAR takes the IR address field |
| mar_ld_sav | output | 1 | MAR takes the save address |
| mbr_ld_mem | output | 1 | MBR takes memory read data |
| mbr_ld_pc | output | 1 | MBR takes PC |
| pc_inc | output | 1 | PC increments |
| pc_ld_isr | output | 1 | PC takes the service-routine address |
| ir_ld_mbr | output | 1 | IR takes MBR |
| ir_adr_ld | output | 1 | IR address field takes the MBR address field |
| acc_ld_add | output | 1 | Register takes register plus MBR |
| acc_ld_and | output | 1 | Register takes register AND MBR |
| bus_rd | output | 1 | System bus read |
| bus_wr | output | 1 | System bus write |

## Verification
On every cycle, the assertions check several local orderings:
- the outputs are quiet during reset;
- the fetch read step follows the MAR-from-PC step;
- a pending request at the end of an execute routine leads into the interrupt entry step;
- fetch resumes after a completed bus write;
- the address and outputs are frozen during a stalled bus step.

Only the bench's sweep can show that whole routines appear in the right order with the right vectors. It runs every opcode against both mode-bit values, with and without an interrupt, and under several memory-stall lengths. The sweep also shows that `irq` and `mem_rdy` are ignored outside the steps that sample them.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UA_W  = 4;
  localparam int CTL_W = 13;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_sav;
    logic mbr_mem;
    logic mbr_pc;
    logic pc_inc;
    logic pc_isr;
    logic ir_all;
    logic ir_adr;
    logic reg_add;
    logic reg_and;
    logic rd;
    logic wr;
  } ctl_t;

  typedef enum logic [2:0] {
    BR_JMP = 3'd0,
    BR_SEQ = 3'd1,
    BR_IND = 3'd2,
    BR_IRQ = 3'd3,
    BR_DSP = 3'd4
  } br_e;

  typedef struct packed {
    ctl_t            ctl;
    br_e             br;
    logic [UA_W-1:0] tgt;
  } uword_t;

  localparam logic [CTL_W-1:0] C_MAR_PC  = 13'h1000;
  localparam logic [CTL_W-1:0] C_MAR_IR  = 13'h0800;
  localparam logic [CTL_W-1:0] C_MAR_SAV = 13'h0400;
  localparam logic [CTL_W-1:0] C_MBR_MEM = 13'h0200;
  localparam logic [CTL_W-1:0] C_MBR_PC  = 13'h0100;
  localparam logic [CTL_W-1:0] C_PC_INC  = 13'h0080;
  localparam logic [CTL_W-1:0] C_PC_ISR  = 13'h0040;
  localparam logic [CTL_W-1:0] C_IR_ALL  = 13'h0020;
  localparam logic [CTL_W-1:0] C_IR_ADR  = 13'h0010;
  localparam logic [CTL_W-1:0] C_ADD     = 13'h0008;
  localparam logic [CTL_W-1:0] C_AND     = 13'h0004;
  localparam logic [CTL_W-1:0] C_RD      = 13'h0002;
  localparam logic [CTL_W-1:0] C_WR      = 13'h0001;

  localparam logic [UA_W-1:0] A_FETCH = 4'd0;
  localparam logic [UA_W-1:0] A_INDIR = 4'd3;
  localparam logic [UA_W-1:0] A_INTR  = 4'd6;
  localparam logic [UA_W-1:0] A_ADD   = 4'd9;
  localparam logic [UA_W-1:0] A_AND   = 4'd12;
  localparam logic [UA_W-1:0] A_IDLE  = 4'd15;

  function automatic uword_t mk_uw(logic [CTL_W-1:0] c, br_e b, logic [UA_W-1:0] t);
    uword_t w;
    w.ctl = ctl_t'(c);
    w.br  = b;
    w.tgt = t;
    return w;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
(
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);

  always_comb begin
    unique case (addr)
      4'd0:    word = mk_uw(C_MAR_PC,                   BR_SEQ, A_FETCH);
      4'd1:    word = mk_uw(C_RD | C_MBR_MEM | C_PC_INC, BR_SEQ, A_FETCH);
      4'd2:    word = mk_uw(C_IR_ALL,                   BR_IND, A_INDIR);
      4'd3:    word = mk_uw(C_MAR_IR,                   BR_SEQ, A_FETCH);
      4'd4:    word = mk_uw(C_RD | C_MBR_MEM,            BR_SEQ, A_FETCH);
      4'd5:    word = mk_uw(C_IR_ADR,                   BR_DSP, A_FETCH);
      4'd6:    word = mk_uw(C_MBR_PC,                   BR_SEQ, A_FETCH);
      4'd7:    word = mk_uw(C_MAR_SAV | C_PC_ISR,       BR_SEQ, A_FETCH);
      4'd8:    word = mk_uw(C_WR,                       BR_JMP, A_FETCH);
      4'd9:    word = mk_uw(C_MAR_IR,                   BR_SEQ, A_FETCH);
      4'd10:   word = mk_uw(C_RD | C_MBR_MEM,            BR_SEQ, A_FETCH);
      4'd11:   word = mk_uw(C_ADD,                      BR_IRQ, A_INTR);
      4'd12:   word = mk_uw(C_MAR_IR,                   BR_SEQ, A_FETCH);
      4'd13:   word = mk_uw(C_RD | C_MBR_MEM,            BR_SEQ, A_FETCH);
      4'd14:   word = mk_uw(C_AND,                      BR_IRQ, A_INTR);
      default: word = mk_uw('0,                         BR_IRQ, A_INTR);
    endcase
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int OP_W = 2
) (
  input  logic [UA_W-1:0] cur,
  input  br_e             br,
  input  logic [UA_W-1:0] tgt,
  input  logic [OP_W-1:0] opcode,
  input  logic            ir_ind,
  input  logic            irq,
  output logic [UA_W-1:0] nxt
);

  logic [UA_W-1:0] disp;

  always_comb begin
    if (opcode == OP_W'(0))      disp = A_AND;
    else if (opcode == OP_W'(1)) disp = A_ADD;
    else                         disp = A_IDLE;
  end

  always_comb begin
    unique case (br)
      BR_JMP:  nxt = tgt;
      BR_SEQ:  nxt = cur + UA_W'(1);
      BR_IND:  nxt = ir_ind ? tgt : disp;
      BR_IRQ:  nxt = irq ? tgt : A_FETCH;
      BR_DSP:  nxt = disp;
      default: nxt = A_FETCH;
    endcase
  end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int OP_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  input  logic            ir_ind,
  input  logic            irq,
  input  logic            mem_rdy,
  output logic            mar_ld_pc,
  output logic            mar_ld_ir,
  output logic            mar_ld_sav,
  output logic            mbr_ld_mem,
  output logic            mbr_ld_pc,
  output logic            pc_inc,
  output logic            pc_ld_isr,
  output logic            ir_ld_mbr,
  output logic            ir_adr_ld,
  output logic            acc_ld_add,
  output logic            acc_ld_and,
  output logic            bus_rd,
  output logic            bus_wr
);

  logic [1:0]      rst_q;
  logic            rst_i;
  logic [UA_W-1:0] car_q;
  logic [UA_W-1:0] car_d;
  uword_t          cbr_q;
  uword_t          rom_word;
  logic            advance;
  logic [CTL_W-1:0] ctl_vec;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  // A bus step waiting on memory freezes the sequencer.
  assign advance = !((cbr_q.ctl.rd || cbr_q.ctl.wr) && !mem_rdy);

  useq_next #(.OP_W(OP_W)) i_next (
    .cur    (car_q),
    .br     (cbr_q.br),
    .tgt    (cbr_q.tgt),
    .opcode (opcode),
    .ir_ind (ir_ind),
    .irq    (irq),
    .nxt    (car_d)
  );

  useq_store i_store (
    .addr (car_d),
    .word (rom_word)
  );

  // Reset word (all zero) is a quiet jump to the fetch entry.
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      car_q <= A_FETCH;
      cbr_q <= '0;
    end else if (advance) begin
      car_q <= car_d;
      cbr_q <= rom_word;
    end
  end

  assign ctl_vec    = cbr_q.ctl;
  assign mar_ld_pc  = cbr_q.ctl.mar_pc;
  assign mar_ld_ir  = cbr_q.ctl.mar_ir;
  assign mar_ld_sav = cbr_q.ctl.mar_sav;
  assign mbr_ld_mem = cbr_q.ctl.mbr_mem;
  assign mbr_ld_pc  = cbr_q.ctl.mbr_pc;
  assign pc_inc     = cbr_q.ctl.pc_inc;
  assign pc_ld_isr  = cbr_q.ctl.pc_isr;
  assign ir_ld_mbr  = cbr_q.ctl.ir_all;
  assign ir_adr_ld  = cbr_q.ctl.ir_adr;
  assign acc_ld_add = cbr_q.ctl.reg_add;
  assign acc_ld_and = cbr_q.ctl.reg_and;
  assign bus_rd     = cbr_q.ctl.rd;
  assign bus_wr     = cbr_q.ctl.wr;

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_i |-> (ctl_vec == '0)); // R1

  AST_FETCH_READ: assert property (@(posedge clk) disable iff (!rst_i)
    mar_ld_pc |=> (bus_rd && mbr_ld_mem && pc_inc)); // R2

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_i)
    ((acc_ld_add || acc_ld_and) && irq) |=> mbr_ld_pc); // R7

  AST_INT_RETURN: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_wr && mem_rdy) |=> mar_ld_pc); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    ((bus_rd || bus_wr) && !mem_rdy) |=> ($stable(car_q) && $stable(ctl_vec))); // R9

endmodule

// File: tb/test_useq_ctrl.sv
module test_useq_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] opcode;
  logic       ir_ind;
  logic       irq;
  logic       mem_rdy;
  logic mar_ld_pc, mar_ld_ir, mar_ld_sav, mbr_ld_mem, mbr_ld_pc, pc_inc, pc_ld_isr;
  logic ir_ld_mbr, ir_adr_ld, acc_ld_add, acc_ld_and, bus_rd, bus_wr;
  logic [12:0] outv;

  int vectors = 0;
  int miscmp  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  useq_ctrl #(.OP_W(2)) i_useq_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .ir_ind(ir_ind), .irq(irq),
    .mem_rdy(mem_rdy), .mar_ld_pc(mar_ld_pc), .mar_ld_ir(mar_ld_ir),
    .mar_ld_sav(mar_ld_sav), .mbr_ld_mem(mbr_ld_mem), .mbr_ld_pc(mbr_ld_pc),
    .pc_inc(pc_inc), .pc_ld_isr(pc_ld_isr), .ir_ld_mbr(ir_ld_mbr),
    .ir_adr_ld(ir_adr_ld), .acc_ld_add(acc_ld_add), .acc_ld_and(acc_ld_and),
    .bus_rd(bus_rd), .bus_wr(bus_wr)
  );

  assign outv = {mar_ld_pc, mar_ld_ir, mar_ld_sav, mbr_ld_mem, mbr_ld_pc, pc_inc,
                 pc_ld_isr, ir_ld_mbr, ir_adr_ld, acc_ld_add, acc_ld_and, bus_rd, bus_wr};

  // Step vectors from the requirements, bit 12 = mar_ld_pc ... bit 0 = bus_wr.
  localparam logic [12:0] S_F1  = 13'd1 << 12;
  localparam logic [12:0] S_F2  = (13'd1 << 9) | (13'd1 << 7) | (13'd1 << 1);
  localparam logic [12:0] S_F3  = 13'd1 << 5;
  localparam logic [12:0] S_MI  = 13'd1 << 11;
  localparam logic [12:0] S_RD  = (13'd1 << 9) | (13'd1 << 1);
  localparam logic [12:0] S_I3  = 13'd1 << 4;
  localparam logic [12:0] S_ADD = 13'd1 << 3;
  localparam logic [12:0] S_AND = 13'd1 << 2;
  localparam logic [12:0] S_T1  = 13'd1 << 8;
  localparam logic [12:0] S_T2  = (13'd1 << 10) | (13'd1 << 6);
  localparam logic [12:0] S_T3  = 13'd1 << 0;

  task automatic chk(input logic [12:0] exp, input string tag);
    vectors++;
    if (outv !== exp) begin
      miscmp++;
      $display("FAIL %s: got %b expected %b", tag, outv, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  endtask

  // One instruction: fetch, optional indirect, opcode routine, optional interrupt.
  task automatic run_instr(input int op, input bit ind, input bit req, input int stl);
    logic [12:0] seq [0:15];
    string       tag [0:15];
    int n = 0;
    seq[n] = S_F1; tag[n] = "R2_fetch1"; n++;
    seq[n] = S_F2; tag[n] = "R2_fetch2"; n++;
    seq[n] = S_F3; tag[n] = "R2_fetch3"; n++;
    if (ind) begin
      seq[n] = S_MI; tag[n] = "R3_ind1"; n++;
      seq[n] = S_RD; tag[n] = "R3_ind2"; n++;
      seq[n] = S_I3; tag[n] = "R3_ind3"; n++;
    end
    if (op == 1) begin
      seq[n] = S_MI;  tag[n] = "R4_add1"; n++;
      seq[n] = S_RD;  tag[n] = "R4_add2"; n++;
      seq[n] = S_ADD; tag[n] = "R4_add3"; n++;
    end else if (op == 0) begin
      seq[n] = S_MI;  tag[n] = "R5_and1"; n++;
      seq[n] = S_RD;  tag[n] = "R5_and2"; n++;
      seq[n] = S_AND; tag[n] = "R5_and3"; n++;
    end else begin
      seq[n] = '0; tag[n] = "R6_idle"; n++;
    end
    if (req) begin
      seq[n] = S_T1; tag[n] = "R7_R8_int1"; n++;
      seq[n] = S_T2; tag[n] = "R8_int2"; n++;
      seq[n] = S_T3; tag[n] = "R8_int3"; n++;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(seq[i], (i == 0) ? "R7_R8_fetch_entry" : tag[i]);
      if (i == 0) begin
        opcode = 2'(op);
        ir_ind = ind;
        irq    = req;
      end
      if (seq[i][1] || seq[i][0]) begin
        mem_rdy = 1'b1;
        for (int k = 0; k < stl; k++) begin
          mem_rdy = 1'b0;
          @(negedge clk);
          chk(seq[i], "R9_stall");
        end
        mem_rdy = 1'b1;
      end else begin
        mem_rdy = (stl % 2 == 1) ? 1'b0 : 1'b1;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; opcode = 2'd0; ir_ind = 1'b0; irq = 1'b0; mem_rdy = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk('0, "R1_in_reset");
    end
    rst_n = 1'b1;
    @(negedge clk); chk('0, "R1_after_release1");
    @(negedge clk); chk('0, "R1_after_release2");
    for (int op = 0; op < 4; op++)
      for (int ind = 0; ind < 2; ind++)
        for (int req = 0; req < 2; req++)
          for (int stl = 0; stl < 3; stl++)
            run_instr(op, ind[0], req[0], stl);
    @(negedge clk);
    chk(S_F1, "R7_R8_final_fetch");
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

endmodule